// File: doc/BRIEF.md
# Serial ADC Lane Deserializer

This block turns one serialized ADC lane back into parallel samples. The lane carries twelve bits per sample and runs at double data rate against a companion bit clock. Each bit-clock cycle therefore delivers two bits: one on the rising edge and one on the falling edge. A separate frame clock runs once per sample. Its rising edge shows where each word begins. The block rebuilds each 12-bit two's-complement word, sign-extends it to 16 bits, and presents it in the frame-clock domain with a valid strobe. That output drives the write side of a dual-clock FIFO, which the system-clock logic reads.

Assembly runs in the bit-clock domain and is controlled by a state machine with three states:
- `ST_HUNT` waits for a word boundary.
- `ST_FILL` collects bit pairs.
- `ST_NEXT` is the single cycle after a word completes, in which the next boundary is due.

The transitions are:
- LOCK: `ST_HUNT` to `ST_FILL` when a boundary is seen.
- RESYNC: `ST_FILL` to `ST_FILL` when a boundary arrives before the word is complete.
- COMPLETE: `ST_FILL` to `ST_NEXT` when the sixth pair arrives.
- CHAIN: `ST_NEXT` to `ST_FILL` when the boundary arrives on time.
- LOST: `ST_NEXT` to `ST_HUNT` when no boundary arrives.

A finished word is parked in a hold register together with a toggle flag. The hold register stays unchanged for at least six bit-clock cycles, so the frame-clock side reads it as a multicycle path and needs no synchronizer.

Top module: `adc_lane_deser`

## Requirements
- R1: While `rst_n` is low, `sample_valid` is 0 and `sample_word` is 0, and both respond asynchronously. After release, `sample_valid` stays 0 at the first two frame-clock rising edges.
- R2: In every bit-clock cycle, the bit sampled on the rising edge sits one position above the bit sampled on the following falling edge. Words arrive MSB first. A word 0x800 sets only the rising bit of the first pair, and 0x400 sets only the falling bit of the first pair.
- R3: A word starts with the rising-edge bit at the first bit-clock rising edge where the frame clock is sampled high after being sampled low. A word is six bit pairs long. Words complete no closer together than six bit-clock cycles.
- R4: Output bits 15:12 are copies of sample bit 11. For example, 0x800 gives 0xF800 and 0x7FF gives 0x07FF.
- R5: A word whose boundary is marked by frame-clock rising edge k appears on `sample_word` at frame-clock rising edge k+2. At that edge `sample_valid` is 1 for one frame-clock cycle.
- R6: With a steady frame clock of six bit-clock cycles per period, a new valid word is delivered at every frame-clock rising edge.
- R7: If a boundary arrives before six pairs are collected, the partial word is dropped and a new word starts at that boundary. The output slot that would have carried the dropped word has `sample_valid` at 0.
- R8: Whenever `sample_valid` is 0, `sample_word` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; data is sampled on both of its edges |
| frame_clk | input | 1 | Sample-rate clock; its rising edge marks a word boundary |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| serial_in | input | 1 | Double-data-rate serial data lane |
| sample_word | output | 16 | Sign-extended sample, in the frame-clock domain |
| sample_valid | output | 1 | High for one frame-clock cycle when `sample_word` holds a new sample |

## Verification
Each result is due at a fixed count of frame-clock rising edges:
- A word framed at edge k is due at edge k+2.
- The slot of a dropped word is due empty at its own k+2.
- After reset release, the first two edges are due empty.

The bench numbers every frame as it drives it and records whether that frame was complete. It samples the outputs 6 ns after each frame-clock rising edge, well away from both clock edges, and compares them against the record of the frame two edges back. Reset values are sampled 1 ns after `rst_n` falls, because the reset is asynchronous.

// File: rtl/adc_lane_deser_pkg.sv
`timescale 1ns/1ps
package adc_lane_deser_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FILL = 2'd1,
        ST_NEXT = 2'd2
    } asm_state_t;

endpackage

// File: rtl/adc_lane_ddr_in.sv
`timescale 1ns/1ps
module adc_lane_ddr_in (
    input  logic       bit_clk,
    input  logic       rst_n,
    input  logic       serial_in,
    input  logic       frame_in,
    output logic [1:0] bit_pair,
    output logic       frame_now,
    output logic       frame_was
);

    logic rise_q;
    logic fall_q;

    // Rising-edge bit and frame level, sampled together.
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q    <= 1'b0;
            frame_now <= 1'b1;
            frame_was <= 1'b1;
        end else begin
            rise_q    <= serial_in;
            frame_now <= frame_in;
            frame_was <= frame_now;
        end
    end

    // Falling-edge bit (the later bit of the pair).
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= serial_in;
        end
    end

    assign bit_pair = {rise_q, fall_q};

endmodule

// File: rtl/adc_lane_word_fsm.sv
`timescale 1ns/1ps
module adc_lane_word_fsm
    import adc_lane_deser_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                bit_clk,
    input  logic                rst_n,
    input  logic [1:0]          bit_pair,
    input  logic                frame_now,
    input  logic                frame_was,
    output logic [SAMPLE_W-1:0] word_hold,
    output logic                word_tgl
);

    localparam int PAIRS = SAMPLE_W / 2;
    localparam int CNT_W = $clog2(PAIRS + 1);

    asm_state_t          state_q;
    asm_state_t          state_d;
    logic [CNT_W-1:0]    pair_cnt;
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] shifted;
    logic                mark;
    logic                last_pair;

    assign mark      = frame_now & ~frame_was;
    assign last_pair = (pair_cnt == CNT_W'(PAIRS - 1));
    assign shifted   = {shreg[SAMPLE_W-3:0], bit_pair};

    // State register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (mark) state_d = ST_FILL;             // LOCK
            ST_FILL: begin
                if (mark)           state_d = ST_FILL;        // RESYNC
                else if (last_pair) state_d = ST_NEXT;        // COMPLETE
            end
            ST_NEXT: state_d = mark ? ST_FILL : ST_HUNT;      // CHAIN / LOST
            default: state_d = ST_HUNT;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_cnt  <= '0;
            shreg     <= '0;
            word_hold <= '0;
            word_tgl  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HUNT, ST_NEXT: begin
                    if (mark) begin
                        shreg    <= shifted;
                        pair_cnt <= CNT_W'(1);
                    end else begin
                        pair_cnt <= '0;
                    end
                end
                ST_FILL: begin
                    shreg <= shifted;
                    if (mark) begin
                        pair_cnt <= CNT_W'(1);
                    end else if (last_pair) begin
                        word_hold <= shifted;
                        word_tgl  <= ~word_tgl;
                        pair_cnt  <= '0;
                    end else begin
                        pair_cnt <= pair_cnt + CNT_W'(1);
                    end
                end
                default: pair_cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/adc_lane_xfer.sv
`timescale 1ns/1ps
module adc_lane_xfer #(
    parameter int SAMPLE_W = 12,
    parameter int OUT_W    = 16
) (
    input  logic                frame_clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] word_hold,
    input  logic                word_tgl,
    output logic [OUT_W-1:0]    sample_word,
    output logic                sample_valid
);

    localparam int EXT_W = OUT_W - SAMPLE_W;

    logic             seen_tgl;
    logic             fresh;
    logic [OUT_W-1:0] ext_word;

    generate
        if (EXT_W > 0) begin : g_sext
            assign ext_word = {{EXT_W{word_hold[SAMPLE_W-1]}}, word_hold};
        end else begin : g_plain
            assign ext_word = word_hold[OUT_W-1:0];
        end
    endgenerate

    assign fresh = word_tgl ^ seen_tgl;

    // word_hold is stable for a full frame: multicycle transfer.
    always_ff @(posedge frame_clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_tgl     <= 1'b0;
            sample_valid <= 1'b0;
            sample_word  <= '0;
        end else begin
            seen_tgl     <= word_tgl;
            sample_valid <= fresh;
            if (fresh) begin
                sample_word <= ext_word;
            end
        end
    end

endmodule

// File: rtl/adc_lane_deser.sv
`timescale 1ns/1ps
module adc_lane_deser #(
    parameter int SAMPLE_W = 12,
    parameter int OUT_W    = 16
) (
    input  logic             bit_clk,
    input  logic             frame_clk,
    input  logic             rst_n,
    input  logic             serial_in,
    output logic [OUT_W-1:0] sample_word,
    output logic             sample_valid
);

    logic [1:0]          bit_pair;
    logic                frame_now;
    logic                frame_was;
    logic [SAMPLE_W-1:0] word_hold;
    logic                word_tgl;

    adc_lane_ddr_in u_ddr (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .serial_in (serial_in),
        .frame_in  (frame_clk),
        .bit_pair  (bit_pair),
        .frame_now (frame_now),
        .frame_was (frame_was)
    );

    adc_lane_word_fsm #(.SAMPLE_W(SAMPLE_W)) u_fsm (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .bit_pair  (bit_pair),
        .frame_now (frame_now),
        .frame_was (frame_was),
        .word_hold (word_hold),
        .word_tgl  (word_tgl)
    );

    adc_lane_xfer #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_xfer (
        .frame_clk    (frame_clk),
        .rst_n        (rst_n),
        .word_hold    (word_hold),
        .word_tgl     (word_tgl),
        .sample_word  (sample_word),
        .sample_valid (sample_valid)
    );

endmodule

// File: rtl/adc_lane_deser_chk.sv
`timescale 1ns/1ps
module adc_lane_deser_chk #(
    parameter int SAMPLE_W = 12,
    parameter int OUT_W    = 16
) (
    input logic             bit_clk,
    input logic             frame_clk,
    input logic             rst_n,
    input logic [OUT_W-1:0] sample_word,
    input logic             sample_valid,
    input logic             word_tgl
);

    localparam int PAIRS = SAMPLE_W / 2;
    localparam int GAP_W = $clog2(PAIRS + 1);

    logic [GAP_W-1:0] gap;
    logic             tgl_d;
    logic [1:0]       frm_cnt;

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap   <= GAP_W'(PAIRS - 1);
            tgl_d <= 1'b0;
        end else begin
            tgl_d <= word_tgl;
            if (word_tgl != tgl_d) begin
                gap <= '0;
            end else if (gap != GAP_W'(PAIRS - 1)) begin
                gap <= gap + GAP_W'(1);
            end
        end
    end

    always_ff @(posedge frame_clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_cnt <= 2'd0;
        end else if (frm_cnt != 2'd3) begin
            frm_cnt <= frm_cnt + 2'd1;
        end
    end

    // R1: nothing valid in the first frame edges after reset
    assert_quiet_after_reset_R1: assert property (
        @(posedge frame_clk) disable iff (!rst_n)
        (frm_cnt < 2'd3) |-> !sample_valid
    );

    // R3: completed words are at least six bit-clock cycles apart
    assert_word_spacing_R3: assert property (
        @(posedge bit_clk) disable iff (!rst_n)
        (word_tgl != tgl_d) |-> (gap >= GAP_W'(PAIRS - 1))
    );

    // R4: upper output bits mirror the sample sign bit
    assert_sign_copy_R4: assert property (
        @(posedge frame_clk) disable iff (!rst_n)
        sample_word[OUT_W-1:SAMPLE_W-1] == {(OUT_W-SAMPLE_W+1){sample_word[SAMPLE_W-1]}}
    );

    // R8: word holds while no valid strobe
    assert_hold_when_idle_R8: assert property (
        @(posedge frame_clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample_word)
    );

endmodule

bind adc_lane_deser adc_lane_deser_chk #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
    .bit_clk      (bit_clk),
    .frame_clk    (frame_clk),
    .rst_n        (rst_n),
    .sample_word  (sample_word),
    .sample_valid (sample_valid),
    .word_tgl     (word_tgl)
);

// File: tb/adc_lane_deser_test.sv
`timescale 1ns/1ps
module adc_lane_deser_test;

    logic        bit_clk   = 1'b0;
    logic        frame_clk = 1'b0;
    logic        rst_n     = 1'b0;
    logic        serial_in = 1'b0;
    logic [15:0] sample_word;
    logic        sample_valid;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;

    // stimulus bookkeeping
    int          hcnt    = 10;
    int          cur_len = 12;
    int          fidx    = 0;
    logic [11:0] cur_word = 12'h000;
    logic [11:0] lf      = 12'hACE;
    logic [11:0] sent [512];
    logic        full [512];
    logic [11:0] feed_w [64];
    int          feed_l [64];
    int          feed_wr = 0;
    int          feed_rd = 0;
    logic [15:0] last_exp = 16'h0000;

    adc_lane_deser uut (
        .bit_clk      (bit_clk),
        .frame_clk    (frame_clk),
        .rst_n        (rst_n),
        .serial_in    (serial_in),
        .sample_word  (sample_word),
        .sample_valid (sample_valid)
    );

    // 200 MHz bit clock
    initial forever #2.5 bit_clk = ~bit_clk;

    // Serializer: after each edge, drive the bit for the next edge.
    always @(bit_clk) begin
        #1;
        hcnt = hcnt + 1;
        if (hcnt >= cur_len) hcnt = 0;
        if (hcnt == 0) begin
            fidx = fidx + 1;
            if (feed_rd < feed_wr) begin
                cur_word = feed_w[feed_rd % 64];
                cur_len  = feed_l[feed_rd % 64];
                feed_rd  = feed_rd + 1;
            end else begin
                lf       = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
                cur_word = lf;
                cur_len  = 12;
            end
            sent[fidx & 511] = cur_word;
            full[fidx & 511] = rst_n && (cur_len == 12);
            frame_clk = 1'b1;
        end else if (hcnt == 6) begin
            frame_clk = 1'b0;
        end
        serial_in = (hcnt < 12) ? cur_word[11 - hcnt] : 1'b0;
    end

    function automatic logic [15:0] sext(input logic [11:0] w);
        return {{4{w[11]}}, w};
    endfunction

    function automatic void push(input logic [11:0] w, input int len);
        feed_w[feed_wr % 64] = w;
        feed_l[feed_wr % 64] = len;
        feed_wr = feed_wr + 1;
    endfunction

    task automatic check_frame(input string tag);
        int          r;
        logic        ev;
        logic [15:0] ew;
        @(posedge frame_clk);
        #6;
        r  = fidx;
        ev = full[(r - 2) & 511];
        ew = ev ? sext(sent[(r - 2) & 511]) : last_exp;
        n_checks = n_checks + 1;
        if (sample_valid !== ev || sample_word !== ew) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: valid=%0b word=%h, expected valid=%0b word=%h",
                     tag, sample_valid, sample_word, ev, ew);
        end
        last_exp = ew;
    endtask

    task automatic check_in_reset(input string tag);
        n_checks = n_checks + 1;
        if (sample_valid !== 1'b0 || sample_word !== 16'h0000) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: valid=%0b word=%h, expected valid=0 word=0000",
                     tag, sample_valid, sample_word);
        end
        last_exp = 16'h0000;
    endtask

    task automatic release_reset();
        @(posedge frame_clk);
        #10;
        rst_n = 1'b1;
    endtask

    // R1: reset values, then quiet first edges
    task automatic t_power_on();
        repeat (4) @(posedge frame_clk);
        #6;
        check_in_reset("R1 reset values");
        release_reset();
        for (int i = 0; i < 4; i++) check_frame("R1 after release");
    endtask

    // R2: pair and bit ordering
    task automatic t_bit_order();
        push(12'h800, 12); push(12'h400, 12); push(12'h200, 12);
        push(12'h002, 12); push(12'h001, 12); push(12'h0C3, 12);
        for (int i = 0; i < 9; i++) check_frame("R2 bit order");
    endtask

    // R4: sign extension corners
    task automatic t_sign();
        push(12'h7FF, 12); push(12'h800, 12); push(12'hFFF, 12);
        push(12'h000, 12); push(12'hAAA, 12); push(12'h555, 12);
        for (int i = 0; i < 9; i++) check_frame("R4 sign extension");
    endtask

    // R5/R6: back-to-back stream
    task automatic t_stream();
        for (int i = 0; i < 30; i++) check_frame("R5 R6 stream");
    endtask

    // R7/R8: early boundary drops partial word, output holds
    task automatic t_resync();
        push(12'h3A5, 12); push(12'hFFF, 8); push(12'h9C6, 12);
        push(12'h123, 12); push(12'h0F0, 10); push(12'hE01, 12);
        for (int i = 0; i < 10; i++) check_frame("R7 R8 resync");
    endtask

    // R1: reset in mid-stream
    task automatic t_reset_mid();
        @(posedge frame_clk);
        #10;
        rst_n = 1'b0;
        #1;
        check_in_reset("R1 mid-stream reset");
        repeat (3) @(posedge frame_clk);
        #6;
        check_in_reset("R1 held reset");
        #4;
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) check_frame("R1 R5 after second release");
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            sent[i] = 12'h000;
            full[i] = 1'b0;
        end
        t_power_on();
        t_bit_order();
        t_sign();
        t_stream();
        t_resync();
        t_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule